// File: doc/BRIEF.md
# Low-Power Wake-Up Input Debouncer

This block watches a small set of external wake-up pins (two by default) and turns a stable level on any of them into a core wake-up request. The pins are not examined every clock. Each one passes through a synchronizer and is then looked at only when a shared sample strobe arrives. A debouncer declares an event once a programmed number of consecutive strobed samples all show that pin's active level. All debouncers share one count setting. Each pin has its own polarity and its own sticky status flag, so software can find out which pin woke the core.

An event can also clear the lower half of a bank of backup registers at once, when the clear enable is set. The block only produces the clear mask; the registers themselves live elsewhere. The wake-up request also collects two alarm inputs, each behind its own enable, and a supply-monitor event that has no enable. The request stays high until the core acknowledges it. The timer that produces the sample strobe is outside this block.

Top module: `lpw_wake_top`

## Requirements
- R1: After reset, `stat_flags`, `wake_req` and `bkp_clr` are all zero.
- R2: With `match_sel` = c, where c is from 1 to 7, a pin's event fires on the strobe that completes c+1 consecutive matching samples. The required count therefore runs from 2 to 8. One strobe fewer gives no event.
- R3: A strobed sample that does not match the active level resets that pin's match count to zero. A full run of c+1 matching samples is then needed again.
- R4: `pin_pol[i]` = 1 makes pin i active high, and 0 makes it active low. Each pin's polarity affects only that pin.
- R5: `match_sel` = 0 disables every debouncer: no strobe count produces an event.
- R6: The match count saturates. A level held across any number of further strobes gives exactly one event. The flag stays clear after a clear, and no further clear pulse appears.
- R7: `stat_flags[i]` is set by an event on pin i. It stays set until `stat_rd` or `stat_clr` is high. An event in the same cycle as a clear wins, and the flag stays set.
- R8: `wake_req` is set by any pin event or any enabled wake source. It stays high until `wake_ack`. A set in the same cycle as `wake_ack` wins.
- R9: `rtc_alarm` wakes the core only when `rtc_wake_en` is 1, and `rtt_alarm` only when `rtt_wake_en` is 1. `supmon_evt` always wakes the core. Each of these raises `wake_req` one cycle later.
- R10: On a pin event with `bkp_clr_en` = 1, `bkp_clr` carries ones in bits 0 to BKP_REGS/2-1 and zeros above. The pulse lasts exactly one cycle, starting the cycle after the completing strobe. With `bkp_clr_en` = 0 it stays zero.
- R11: Pins are looked at only on `sample_stb`. Holding an active level with no strobe produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPIN | Raw wake-up pins (asynchronous) |
| pin_pol | input | NPIN | Per-pin active level, 1 = high |
| match_sel | input | 3 | Shared count code: 0 = off, c = c+1 samples |
| bkp_clr_en | input | 1 | Allow events to clear the lower backup half |
| rtc_alarm | input | 1 | Calendar alarm wake source |
| rtc_wake_en | input | 1 | Enable for `rtc_alarm` |
| rtt_alarm | input | 1 | Interval timer alarm wake source |
| rtt_wake_en | input | 1 | Enable for `rtt_alarm` |
| supmon_evt | input | 1 | Supply-monitor wake source |
| sample_stb | input | 1 | Shared one-cycle sample strobe |
| stat_rd | input | 1 | Status read, clears flags |
| stat_clr | input | 1 | Explicit status clear |
| wake_ack | input | 1 | Core acknowledge of `wake_req` |
| stat_flags | output | NPIN | Sticky per-pin event flags |
| wake_req | output | 1 | Held core wake-up request |
| bkp_clr | output | BKP_REGS | One-cycle backup clear mask |

## Verification
A pin change reaches the sampling point after two clock edges, because of the two-stage synchronizer. The bench therefore waits three cycles after moving a pin before it strobes. For a strobe held across edge E, the `bkp_clr` pulse is due in the cycle right after E. `stat_flags` and `wake_req` follow one edge later. Alarms and the supply monitor reach `wake_req` one edge after they are presented. The strobe task reads `bkp_clr` at the falling edge after E, and reads flags and the request at the falling edge after that. Collision cases place the clear or acknowledge on the edge where the event lands.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
   localparam int unsigned CFG_W = 3;
   localparam int unsigned CNT_W = CFG_W + 1;

   typedef logic [CFG_W-1:0] match_code_t;
   typedef logic [CNT_W-1:0] match_cnt_t;

   // code 0 switches the debouncers off; code c asks for c+1 samples
   function automatic match_cnt_t code_to_target(match_code_t code);
      return match_cnt_t'(code) + match_cnt_t'(1);
   endfunction

   function automatic logic code_enabled(match_code_t code);
      return code != '0;
   endfunction
endpackage

// File: rtl/lpw_debounce.sv
module lpw_debounce #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = lpw_pkg::CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_async,
   input  logic             active_hi,
   input  logic             sample_stb,
   input  logic             enable,
   input  logic [CNT_W-1:0] target,
   output logic             evt_pulse
);
   logic             pin_s;
   logic             match;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pin_s = pin_async;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[SYNC_STAGES-2:0], pin_async};
         end
         assign pin_s = sr[SYNC_STAGES-1];
      end
   endgenerate

   assign match   = (pin_s == active_hi);
   assign cnt_inc = cnt + {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         evt_pulse <= 1'b0;
      end else begin
         evt_pulse <= 1'b0;
         if (sample_stb) begin
            if (!enable || !match) begin
               cnt <= '0;
            end else if (cnt < target) begin
               cnt       <= cnt_inc;
               evt_pulse <= (cnt_inc == target);
            end
         end
      end
   end
endmodule

// File: rtl/lpw_status.sv
module lpw_status #(
   parameter int unsigned NPIN = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] evt,
   input  logic            rd,
   input  logic            clr,
   output logic [NPIN-1:0] flags
);
   logic wipe;
   assign wipe = rd | clr;

   // a fresh event outranks a clear landing in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & {NPIN{~wipe}}) | evt;
   end
endmodule

// File: rtl/lpw_wake.sv
module lpw_wake #(
   parameter int unsigned NPIN     = 2,
   parameter int unsigned BKP_REGS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NPIN-1:0]     evt,
   input  logic                bkp_clr_en,
   input  logic                rtc_alarm,
   input  logic                rtc_wake_en,
   input  logic                rtt_alarm,
   input  logic                rtt_wake_en,
   input  logic                supmon_evt,
   input  logic                wake_ack,
   output logic                wake_req,
   output logic [BKP_REGS-1:0] bkp_clr
);
   localparam int unsigned HALF = BKP_REGS / 2;
   localparam logic [BKP_REGS-1:0] LOW_MASK = {{(BKP_REGS-HALF){1'b0}}, {HALF{1'b1}}};

   logic any_evt;
   logic wake_set;

   assign any_evt  = |evt;
   assign wake_set = any_evt
                   | (rtc_alarm & rtc_wake_en)
                   | (rtt_alarm & rtt_wake_en)
                   | supmon_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_req <= 1'b0;
      else        wake_req <= wake_set | (wake_req & ~wake_ack);
   end

   // evt is already a registered one-cycle pulse: no added delay
   assign bkp_clr = (any_evt && bkp_clr_en) ? LOW_MASK : '0;
endmodule

// File: rtl/lpw_wake_top.sv
module lpw_wake_top #(
   parameter int unsigned NPIN        = 2,
   parameter int unsigned BKP_REGS    = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NPIN-1:0]            pin_in,
   input  logic [NPIN-1:0]            pin_pol,
   input  logic [lpw_pkg::CFG_W-1:0]  match_sel,
   input  logic                       bkp_clr_en,
   input  logic                       rtc_alarm,
   input  logic                       rtc_wake_en,
   input  logic                       rtt_alarm,
   input  logic                       rtt_wake_en,
   input  logic                       supmon_evt,
   input  logic                       sample_stb,
   input  logic                       stat_rd,
   input  logic                       stat_clr,
   input  logic                       wake_ack,
   output logic [NPIN-1:0]            stat_flags,
   output logic                       wake_req,
   output logic [BKP_REGS-1:0]        bkp_clr
);
   import lpw_pkg::*;

   generate
      if (NPIN < 1) begin : g_bad_npin
         $error("lpw_wake_top: NPIN must be at least 1");
      end
      if (BKP_REGS < 2 || (BKP_REGS % 2) != 0) begin : g_bad_bkp
         $error("lpw_wake_top: BKP_REGS must be even and at least 2");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("lpw_wake_top: SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   match_cnt_t      target;
   logic            dbn_en;
   logic [NPIN-1:0] evt;

   assign target = code_to_target(match_sel);
   assign dbn_en = code_enabled(match_sel);

   generate
      for (genvar i = 0; i < NPIN; i++) begin : g_pin
         lpw_debounce #(
            .SYNC_STAGES(SYNC_STAGES),
            .CNT_W      (CNT_W)
         ) u_dbn (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (pin_in[i]),
            .active_hi (pin_pol[i]),
            .sample_stb(sample_stb),
            .enable    (dbn_en),
            .target    (target),
            .evt_pulse (evt[i])
         );
      end
   endgenerate

   lpw_status #(.NPIN(NPIN)) u_status (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (evt),
      .rd   (stat_rd),
      .clr  (stat_clr),
      .flags(stat_flags)
   );

   lpw_wake #(.NPIN(NPIN), .BKP_REGS(BKP_REGS)) u_wake (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .bkp_clr_en (bkp_clr_en),
      .rtc_alarm  (rtc_alarm),
      .rtc_wake_en(rtc_wake_en),
      .rtt_alarm  (rtt_alarm),
      .rtt_wake_en(rtt_wake_en),
      .supmon_evt (supmon_evt),
      .wake_ack   (wake_ack),
      .wake_req   (wake_req),
      .bkp_clr    (bkp_clr)
   );
endmodule

// File: rtl/lpw_wake_chk.sv
module lpw_wake_chk #(
   parameter int unsigned NPIN     = 2,
   parameter int unsigned BKP_REGS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sample_stb,
   input logic                stat_rd,
   input logic                stat_clr,
   input logic                wake_ack,
   input logic                bkp_clr_en,
   input logic                rtc_alarm,
   input logic                rtc_wake_en,
   input logic                supmon_evt,
   input logic [NPIN-1:0]     stat_flags,
   input logic                wake_req,
   input logic [BKP_REGS-1:0] bkp_clr
);
   localparam int unsigned HALF = BKP_REGS / 2;
   localparam logic [BKP_REGS-1:0] LOW_MASK = {{(BKP_REGS-HALF){1'b0}}, {HALF{1'b1}}};

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_rd && !stat_clr) |=> ((stat_flags & $past(stat_flags)) == $past(stat_flags)));

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_req && !wake_ack) |=> wake_req);

   a_r9_rtc_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (rtc_alarm && rtc_wake_en) |=> wake_req);

   a_r9_supmon_wake: assert property (@(posedge clk) disable iff (!rst_n)
      supmon_evt |=> wake_req);

   a_r10_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (bkp_clr != '0) |-> (bkp_clr == LOW_MASK && bkp_clr_en));

   a_r10_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (bkp_clr != '0) |=> (stat_flags != '0 && wake_req));

   a_r11_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_flags & ~$past(stat_flags)) != '0) |-> $past(sample_stb, 2));
endmodule

bind lpw_wake_top lpw_wake_chk #(.NPIN(NPIN), .BKP_REGS(BKP_REGS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sample_stb (sample_stb),
   .stat_rd    (stat_rd),
   .stat_clr   (stat_clr),
   .wake_ack   (wake_ack),
   .bkp_clr_en (bkp_clr_en),
   .rtc_alarm  (rtc_alarm),
   .rtc_wake_en(rtc_wake_en),
   .supmon_evt (supmon_evt),
   .stat_flags (stat_flags),
   .wake_req   (wake_req),
   .bkp_clr    (bkp_clr)
);

// File: tb/tb_lpw_wake_top.sv
`timescale 1ns/1ps
module tb_lpw_wake_top;
   localparam int NPIN = 2;
   localparam int BKP  = 8;
   localparam logic [BKP-1:0] LOW = 8'h0F;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NPIN-1:0] pin_in = '0, pin_pol = '1;
   logic [2:0]      match_sel = '0;
   logic bkp_clr_en = 0, rtc_alarm = 0, rtc_wake_en = 0, rtt_alarm = 0, rtt_wake_en = 0;
   logic supmon_evt = 0, sample_stb = 0, stat_rd = 0, stat_clr = 0, wake_ack = 0;
   logic [NPIN-1:0] stat_flags;
   logic            wake_req;
   logic [BKP-1:0]  bkp_clr;
   logic [BKP-1:0]  seen_bkp;

   int tests = 0, fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   lpw_wake_top #(.NPIN(NPIN), .BKP_REGS(BKP)) dut (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_pins(logic [NPIN-1:0] v);
      pin_in = v;
      repeat (3) @(negedge clk);
   endtask

   // bkp_clr due the cycle after the strobe edge; flags and request one edge later
   task automatic strobe();
      sample_stb = 1;
      @(negedge clk);
      sample_stb = 0;
      seen_bkp = bkp_clr;
      @(negedge clk);
   endtask

   task automatic clear_all();
      stat_clr = 1; wake_ack = 1;
      @(negedge clk);
      stat_clr = 0; wake_ack = 0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      chk("R1 flags", stat_flags, 0);
      chk("R1 wake", wake_req, 0);
      chk("R1 bkp", bkp_clr, 0);
      rst_n = 1;
      @(negedge clk);

      // R2 R4 R5 R6 R10: sweep pin, polarity and every count code
      for (int p = 0; p < NPIN; p++) begin
         for (int pol = 0; pol < 2; pol++) begin
            for (int c = 0; c < 8; c++) begin
               logic [NPIN-1:0] idle, act;
               match_sel  = 3'(c);
               bkp_clr_en = pol[0];
               pin_pol    = '1;
               pin_pol[p] = pol[0];
               idle       = '0;
               idle[p]    = ~pol[0];
               act        = idle;
               act[p]     = pol[0];
               set_pins(idle);
               strobe();
               clear_all();
               set_pins(act);
               for (int k = 1; k <= 10; k++) begin
                  logic fire, hit;
                  fire = (c != 0) && (k >= c + 1);
                  hit  = (c != 0) && (k == c + 1);
                  strobe();
                  chk("R2/R4/R5 flag", stat_flags, fire ? (1 << p) : 0);
                  chk("R8 wake from pin", wake_req, fire);
                  chk("R10/R6 bkp pulse", seen_bkp, (hit && pol[0]) ? LOW : 0);
                  chk("R10 one cycle", bkp_clr, 0);
               end
               // R6: held level, no second event after a clear
               clear_all();
               strobe(); strobe(); strobe();
               chk("R6 saturate", stat_flags, 0);
            end
         end
      end

      // R3: a miss restarts the count (code 3 -> 4 samples)
      match_sel = 3; pin_pol = '1; bkp_clr_en = 0;
      set_pins(0); strobe(); clear_all();
      set_pins(2'b01);
      strobe(); strobe(); strobe();
      set_pins(0); strobe();
      set_pins(2'b01);
      strobe(); strobe(); strobe();
      chk("R3 restart no event", stat_flags, 0);
      strobe();
      chk("R3 event after full run", stat_flags, 2'b01);

      // R7: read clears; clear in the same cycle as a new event loses
      stat_rd = 1; @(negedge clk); stat_rd = 0; @(negedge clk);
      chk("R7 read clears", stat_flags, 0);
      set_pins(0); strobe(); clear_all();
      match_sel = 1;
      set_pins(2'b10);
      strobe();
      sample_stb = 1; @(negedge clk);
      sample_stb = 0; stat_clr = 1; @(negedge clk);
      stat_clr = 0;
      chk("R7 event beats clear", stat_flags, 2'b10);
      @(negedge clk);
      chk("R7 sticky", stat_flags, 2'b10);

      // R11: active level with no strobe
      set_pins(0); strobe(); clear_all();
      set_pins(2'b11);
      repeat (20) @(negedge clk);
      chk("R11 no strobe no event", stat_flags, 0);
      chk("R11 no wake", wake_req, 0);
      set_pins(0);

      // R8 R9: alarm gating, supply monitor, ack priority
      clear_all();
      rtc_alarm = 1; @(negedge clk); rtc_alarm = 0; @(negedge clk);
      chk("R9 rtc gated off", wake_req, 0);
      rtt_alarm = 1; @(negedge clk); rtt_alarm = 0; @(negedge clk);
      chk("R9 rtt gated off", wake_req, 0);
      rtc_wake_en = 1; rtc_alarm = 1; @(negedge clk); rtc_alarm = 0;
      chk("R9 rtc wake", wake_req, 1);
      repeat (3) @(negedge clk);
      chk("R8 held", wake_req, 1);
      wake_ack = 1; @(negedge clk); wake_ack = 0;
      chk("R8 ack clears", wake_req, 0);
      rtt_wake_en = 1; rtt_alarm = 1; @(negedge clk); rtt_alarm = 0;
      chk("R9 rtt wake", wake_req, 1);
      wake_ack = 1; @(negedge clk); wake_ack = 0;
      supmon_evt = 1; @(negedge clk); supmon_evt = 0;
      chk("R9 supmon wake", wake_req, 1);
      supmon_evt = 1; wake_ack = 1; @(negedge clk);
      supmon_evt = 0; wake_ack = 0;
      chk("R8 set beats ack", wake_req, 1);
      chk("R8 no status for alarms", stat_flags, 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule